// File: doc/BRIEF.md
# Transmit Byte Queue with Level Trigger and Debug Hold

This block is a synchronous 16-entry byte queue that sits between a producer of transmit bytes and a serial transmitter. Bytes enter through a valid/ready write stream; the transmitter draws them from a valid/ready read stream. Three plain control inputs shape the behaviour: a 5-bit threshold, a flush bit and a hold bit.

The block keeps a registered occupancy count. It raises a level-sensitive trigger flag whenever that count is strictly below the threshold, so upstream logic can refill the queue. While the flush input is high, the queue is emptied on every clock edge. While the hold input is high, reads return the head byte but leave it in place, so the transmit path can be inspected. A write offered to a full queue and a read requested from an empty queue each produce a one-cycle error pulse.

Back-pressure rules: a byte is taken on a clock edge only when `wr_valid` and `wr_ready` are both high, and `wr_ready` is low exactly when the queue holds 16 bytes. `rd_valid` is high exactly when the queue is not empty. `rd_data` shows the head byte in that case and zero otherwise. A read happens on an edge where `rd_ready` is high.

Top module: `txq_trig_fifo`

## Requirements
- R1: After reset, count is 0, `q_empty` is 1, `q_full`, `trig`, `ovf_pulse` and `udf_pulse` are 0, and `wr_ready` is 1.
- R2: A byte is stored when `wr_valid` and `wr_ready` are both high at an edge. `wr_ready` equals not-full. Bytes leave in the order they entered.
- R3: With `hold` low, a read (`rd_ready` high, `rd_valid` high) presents the head byte on `rd_data` before the edge and removes it at the edge.
- R4: With `hold` high, a read presents the head byte, and the count does not go down.
- R5: `trig` is registered and equals 1 when the count after the edge is strictly less than `cfg_level`. A level of 0 never raises it, and a level of 17 or more always raises it.
- R6: When `flush` is high at an edge, the count becomes 0 and no byte offered in that cycle is kept. Flush takes priority over push, pop and both error pulses. Holding `flush` high keeps the queue empty.
- R7: A write offered while the queue is full (and `flush` is low) is dropped, and `ovf_pulse` is high for the one cycle after that edge.
- R8: A read requested while the queue is empty (and `flush` is low) gives `rd_data` = 0, removes nothing, and makes `udf_pulse` high for the one cycle after that edge.
- R9: An accepted push and a pop in the same cycle, on a queue that is neither empty nor full, leave the count unchanged.
- R10: `q_full`, `q_empty` and `count` are registered. After each edge they reflect the occupancy that results from that edge's operations. `rd_valid` equals not-empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_level | input | 5 | Trigger threshold |
| flush | input | 1 | Synchronous queue clear |
| hold | input | 1 | Non-destructive read mode |
| wr_valid | input | 1 | Producer offers a byte |
| wr_data | input | 8 | Byte offered |
| wr_ready | output | 1 | Queue can take a byte |
| rd_valid | output | 1 | Head byte available |
| rd_data | output | 8 | Head byte, or zero when empty |
| rd_ready | input | 1 | Transmitter reads |
| count | output | 5 | Stored bytes, 0 to 16 |
| q_full | output | 1 | Count is 16 |
| q_empty | output | 1 | Count is 0 |
| trig | output | 1 | Count below threshold |
| ovf_pulse | output | 1 | Write refused while full |
| udf_pulse | output | 1 | Read requested while empty |

## Verification
`wr_ready`, `rd_valid` and `rd_data` follow the registered state through logic only, so they are checked in the same cycle as the stimulus, after the inputs settle and before the edge. `count`, `q_full`, `q_empty`, `trig` and both pulses are due one edge later. The bench applies inputs shortly after a rising edge, checks the combinational outputs one nanosecond later, then waits for the next rising edge and checks the registered outputs one nanosecond after it against a queue model that was advanced at that same edge.

// File: rtl/txq_pkg.sv
package txq_pkg;
  typedef struct packed {
    logic push;
    logic pop;
    logic flush;
  } txq_op_t;
endpackage

// File: rtl/txq_store.sv
module txq_store #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  txq_pkg::txq_op_t op,
  input  logic [W-1:0]  wr_data,
  output logic [W-1:0]  head_data
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || op.flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (op.push) wr_ptr <= bump(wr_ptr);
      if (op.pop)  rd_ptr <= bump(rd_ptr);
    end
  end

  always_ff @(posedge clk) begin
    if (op.push && !op.flush) mem[wr_ptr] <= wr_data;
  end

  assign head_data = mem[rd_ptr];
endmodule

// File: rtl/txq_level.sv
module txq_level #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned LW    = 5,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  txq_pkg::txq_op_t op,
  input  logic [LW-1:0]    level,
  output logic [CW-1:0]    count,
  output logic             full,
  output logic             empty,
  output logic             trig
);
  logic [CW-1:0] cnt_nxt;

  always_comb begin
    if (op.flush) cnt_nxt = '0;
    else          cnt_nxt = count + CW'(op.push) - CW'(op.pop);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      full  <= 1'b0;
      empty <= 1'b1;
      trig  <= 1'b0;
    end else begin
      count <= cnt_nxt;
      full  <= (cnt_nxt == CW'(DEPTH));
      empty <= (cnt_nxt == '0);
      trig  <= (int'(cnt_nxt) < int'(level));
    end
  end
endmodule

// File: rtl/txq_trig_fifo.sv
module txq_trig_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 16,
  parameter int unsigned LW    = 5,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] cfg_level,
  input  logic          flush,
  input  logic          hold,
  input  logic          wr_valid,
  input  logic [W-1:0]  wr_data,
  output logic          wr_ready,
  output logic          rd_valid,
  output logic [W-1:0]  rd_data,
  input  logic          rd_ready,
  output logic [CW-1:0] count,
  output logic          q_full,
  output logic          q_empty,
  output logic          trig,
  output logic          ovf_pulse,
  output logic          udf_pulse
);
  txq_pkg::txq_op_t op;
  logic [W-1:0]     head;

  assign wr_ready = !q_full;
  assign rd_valid = !q_empty;

  always_comb begin
    op.flush = flush;
    op.push  = wr_valid && wr_ready && !flush;
    op.pop   = rd_ready && rd_valid && !hold && !flush;
  end

  txq_store #(.W(W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .op(op), .wr_data(wr_data), .head_data(head)
  );

  txq_level #(.DEPTH(DEPTH), .LW(LW)) u_level (
    .clk(clk), .rst_n(rst_n), .op(op), .level(cfg_level),
    .count(count), .full(q_full), .empty(q_empty), .trig(trig)
  );

  assign rd_data = rd_valid ? head : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_pulse <= 1'b0;
      udf_pulse <= 1'b0;
    end else begin
      ovf_pulse <= !flush && wr_valid && q_full;
      udf_pulse <= !flush && rd_ready && q_empty;
    end
  end
endmodule

// File: rtl/txq_trig_fifo_chk.sv
module txq_trig_fifo_chk #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 16,
  parameter int unsigned LW    = 5,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [LW-1:0] cfg_level,
  input logic          flush,
  input logic          hold,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic          rd_valid,
  input logic [W-1:0]  rd_data,
  input logic          rd_ready,
  input logic [CW-1:0] count,
  input logic          q_full,
  input logic          q_empty,
  input logic          trig,
  input logic          ovf_pulse,
  input logic          udf_pulse
);
  // R6
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0) && q_empty);
  // R4
  hold_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && rd_ready && rd_valid && !flush) |=> (count >= $past(count)));
  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && q_full && !flush) |=> (ovf_pulse && (count <= $past(count))));
  // R8
  underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ready && q_empty && !flush) |=> udf_pulse);
  // R8
  empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> (rd_data == '0));
  // R5
  level_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(cfg_level) && cfg_level == '0) |-> !trig);
  // R10
  full_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_full |-> (count == CW'(DEPTH)) && !q_empty);
endmodule

bind txq_trig_fifo txq_trig_fifo_chk #(.W(W), .DEPTH(DEPTH), .LW(LW)) u_chk (.*);

// File: tb/tb_txq_trig_fifo.sv
`timescale 1ns/1ps
module tb_txq_trig_fifo;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [4:0] cfg_level;
  logic       flush, hold, wr_valid, rd_ready;
  logic [7:0] wr_data;
  logic       wr_ready, rd_valid, q_full, q_empty, trig, ovf_pulse, udf_pulse;
  logic [7:0] rd_data;
  logic [4:0] count;

  int errors = 0;
  int checks = 0;
  logic [7:0] q[$];
  bit done = 0;

  always #2.5 clk = ~clk;

  txq_trig_fifo dut (.*);

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input bit wv, input logic [7:0] wd, input bit rr,
                      input bit fl, input bit hd, input logic [4:0] lv);
    int sz;
    bit ovf_e, udf_e;
    string ctag;
    wr_valid = wv; wr_data = wd; rd_ready = rr; flush = fl; hold = hd; cfg_level = lv;
    #1;
    sz = q.size();
    chk("R2", "wr_ready", int'(wr_ready), int'(sz < 16));
    chk("R10", "rd_valid", int'(rd_valid), int'(sz > 0));
    if (rr) chk(sz == 0 ? "R8" : (hd ? "R4" : "R3"), "rd_data",
                int'(rd_data), sz > 0 ? int'(q[0]) : 0);
    ovf_e = !fl && wv && sz == 16;
    udf_e = !fl && rr && sz == 0;
    if (fl) q.delete();
    else begin
      if (rr && sz > 0 && !hd) void'(q.pop_front());
      if (wv && sz < 16) q.push_back(wd);
    end
    ctag = fl ? "R6" : (hd && rr) ? "R4" : (wv && rr && sz > 0 && sz < 16) ? "R9" : "R2";
    @(posedge clk); #1;
    sz = q.size();
    chk(ctag, "count", int'(count), sz);
    chk("R10", "q_full", int'(q_full), int'(sz == 16));
    chk("R10", "q_empty", int'(q_empty), int'(sz == 0));
    chk("R5", "trig", int'(trig), int'(sz < int'(lv)));
    chk("R7", "ovf_pulse", int'(ovf_pulse), int'(ovf_e));
    chk("R8", "udf_pulse", int'(udf_pulse), int'(udf_e));
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 0; cfg_level = 0; flush = 0; hold = 0; wr_valid = 0; wr_data = 0; rd_ready = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    chk("R1", "count", int'(count), 0);
    chk("R1", "q_empty", int'(q_empty), 1);
    chk("R1", "q_full", int'(q_full), 0);
    chk("R1", "trig", int'(trig), 0);
    chk("R1", "pulses", int'({ovf_pulse, udf_pulse}), 0);
    chk("R1", "wr_ready", int'(wr_ready), 1);
    // R8: read from empty
    step(0, 8'h00, 1, 0, 0, 5'd0);
    // R2/R5: fill with a threshold above depth (trig always)
    for (int i = 0; i < 16; i++) step(1, 8'(8'h10 + i), 0, 0, 0, 5'd20);
    // R7: push while full
    step(1, 8'hEE, 0, 0, 0, 5'd20);
    // R4: held reads do not pop
    for (int i = 0; i < 3; i++) step(0, 8'h00, 1, 0, 1, 5'd8);
    // R3: drain in order, level 4 watches the crossing
    for (int i = 0; i < 16; i++) step(0, 8'h00, 1, 0, 0, 5'd4);
    // R8 again, with a push in the same cycle
    step(1, 8'hA5, 1, 0, 0, 5'd1);
    // R9: push and pop together mid-level
    step(1, 8'h5A, 0, 0, 0, 5'd1);
    for (int i = 0; i < 4; i++) step(1, 8'(8'h30 + i), 1, 0, 0, 5'd1);
    // R6: one-cycle flush with push and read offered
    step(1, 8'h77, 1, 1, 0, 5'd3);
    // R6: held flush with pushes
    for (int i = 0; i < 2; i++) step(1, 8'h66, 0, 0, 0, 5'd3);
    for (int i = 0; i < 4; i++) step(1, 8'(8'h40 + i), 0, 1, 0, 5'd3);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      automatic int r = $urandom_range(0, 99);
      step(r < 55, 8'($urandom), $urandom_range(0, 99) < 45, r == 99,
           $urandom_range(0, 9) == 0, 5'($urandom_range(0, 18)));
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule